// File: doc/BRIEF.md
# Immediate-Load Sequencer with Register File

This block runs the move-immediate instruction family of a small 8-bit processor. It reads an opcode byte and then an 8-bit data byte over a simple synchronous memory read port. It writes the data byte into the destination register that the opcode encodes. It holds an accumulator and six general registers. A byte read port reads any one register, and a pair read port reads the 16-bit register pairs.

A T-state counter sequences each instruction as two machine cycles. The opcode fetch takes four T-states, the last of which decodes the opcode. The memory read takes three T-states. The program counter steps once for every byte read. A status output names the current machine cycle, and single-cycle pulses mark a completed instruction or a rejected opcode. Any byte outside the family counts as a one-byte no-op and is flagged.

Top module: `imm_load_seq`

## Requirements
- R1: Asserting rst_ni clears the program counter and all seven registers to 0 and forces the machine-cycle status to idle with done_o and illegal_o low, without waiting for a clock edge.
- R2: The opcode fetch has status 2'b01 and runs T-states 1, 2, 3, 4. mem_rd_o is high in T2 and T3 only, and the opcode is taken from mem_data_i at the edge that ends T3.
- R3: The memory read has status 2'b10 and runs T-states 1, 2, 3 with mem_rd_o high in T2 and T3. A legal instruction takes 7 clock cycles from fetch T1 to its last T-state, and the next fetch T1 follows at once.
- R4: A legal opcode has the form 00_ddd_110. The field ddd (bits 5:3) picks the destination: 000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 111 A. These are the opcodes 06, 0E, 16, 1E, 26, 2E, 3E (hex).
- R5: The data byte read in memory-read T3 overwrites the destination register. No other register changes.
- R6: The program counter increments by 1 at the edge ending each T3 in which a byte is read, and holds at every other edge. It advances by 2 per legal instruction.
- R7: done_o is high for exactly the memory-read T3 of each legal instruction.
- R8: Any other opcode, including 00_110_110, raises illegal_o during fetch T4, changes no register and advances the program counter by 1 in total. It is followed directly by a new fetch T1.
- R9: rd_data_o returns the register that rd_sel_i selects, in the R4 encoding. Code 110 returns 0.
- R10: pair_data_o returns pair_sel_i 00 = {B,C}, 01 = {D,E}, 10 = {H,L}, with the first-named register in bits 15:8. Code 11 returns 0.
- R11: While reset is held the status is idle (2'b00). The first clock edge after release enters fetch T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 16 | Memory read address (program counter) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_data_i | input | 8 | Memory read data |
| mcycle_o | output | 2 | Machine-cycle status: 00 idle, 01 fetch, 10 read |
| tstate_o | output | 3 | Current T-state, 1-based (0 when idle) |
| pc_o | output | 16 | Program counter |
| done_o | output | 1 | Instruction-complete pulse |
| illegal_o | output | 1 | Unrecognised-opcode pulse |
| rd_sel_i | input | 3 | Byte read select (R4 encoding) |
| rd_data_o | output | 8 | Selected register contents |
| pair_sel_i | input | 2 | Pair read select |
| pair_data_o | output | 16 | Selected register pair |

## Verification
The bench targets several corner cases. It runs every destination code and overwrites registers that were already written, so a wrong field decode or a write to the wrong register shows up as a wrong value on the read ports. It then places the hole code 00_110_110 and other bytes from outside the family next to legal opcodes. A design that decodes the pattern too loosely would write a register and consume two bytes, so its program counter and cycle pattern would drift from the model. The bench also checks the 7-cycle gap between completion pulses, the unused read-select codes, and an asynchronous reset taken mid-run with loaded registers.

// File: rtl/ils_pkg.sv
package ils_pkg;
  typedef enum logic [1:0] {
    MC_IDLE  = 2'b00,
    MC_FETCH = 2'b01,
    MC_READ  = 2'b10
  } mcycle_e;

  localparam int unsigned TS_W = 3;
  localparam logic [TS_W-1:0] T_ONE      = 3'd1;
  localparam logic [TS_W-1:0] T_STROBE   = 3'd2;
  localparam logic [TS_W-1:0] T_SAMPLE   = 3'd3;
  localparam logic [TS_W-1:0] FETCH_LAST = 3'd4;
  localparam logic [TS_W-1:0] READ_LAST  = 3'd3;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_SEL  = 1 << SEL_W;
  localparam logic [SEL_W-1:0] SEL_HOLE = 3'b110;
  localparam int unsigned NUM_PAIRS = 3;

  localparam logic [1:0] OP_HI_FIX = 2'b00;
  localparam logic [2:0] OP_LO_FIX = 3'b110;
endpackage

// File: rtl/ils_decode.sv
module ils_decode
  import ils_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] opcode_i,
  output logic              legal_o,
  output logic [SEL_W-1:0]  dst_o
);
  assign dst_o   = opcode_i[5:3];
  assign legal_o = (opcode_i[7:6] == OP_HI_FIX) &&
                   (opcode_i[2:0] == OP_LO_FIX) &&
                   (opcode_i[5:3] != SEL_HOLE);
endmodule

// File: rtl/ils_seq.sv
module ils_seq
  import ils_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            legal_i,
  output mcycle_e         mcycle_o,
  output logic [TS_W-1:0] tstate_o,
  output logic            rd_o,
  output logic            op_take_o,
  output logic            data_take_o,
  output logic            done_o,
  output logic            illegal_o
);
  mcycle_e         mc_q;
  logic [TS_W-1:0] t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_q <= MC_IDLE;
      t_q  <= '0;
    end else begin
      unique case (mc_q)
        MC_IDLE: begin
          mc_q <= MC_FETCH;
          t_q  <= T_ONE;
        end
        MC_FETCH: begin
          if (t_q == FETCH_LAST) begin
            mc_q <= legal_i ? MC_READ : MC_FETCH;
            t_q  <= T_ONE;
          end else begin
            t_q <= t_q + 1'b1;
          end
        end
        MC_READ: begin
          if (t_q == READ_LAST) begin
            mc_q <= MC_FETCH;
            t_q  <= T_ONE;
          end else begin
            t_q <= t_q + 1'b1;
          end
        end
        default: begin
          mc_q <= MC_IDLE;
          t_q  <= '0;
        end
      endcase
    end
  end

  logic busy;
  assign busy        = (mc_q != MC_IDLE);
  assign mcycle_o    = mc_q;
  assign tstate_o    = t_q;
  assign rd_o        = busy && (t_q >= T_STROBE) && (t_q <= T_SAMPLE);
  assign op_take_o   = (mc_q == MC_FETCH) && (t_q == T_SAMPLE);
  assign data_take_o = (mc_q == MC_READ) && (t_q == READ_LAST);
  assign done_o      = data_take_o;
  assign illegal_o   = (mc_q == MC_FETCH) && (t_q == FETCH_LAST) && !legal_i;
endmodule

// File: rtl/ils_regfile.sv
module ils_regfile
  import ils_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  wsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [1:0]        pair_sel_i,
  output logic [2*DATA_W-1:0] pair_data_o
);
  logic [NUM_SEL-1:0][DATA_W-1:0] regs_w;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_reg
    if (g == int'(SEL_HOLE)) begin : g_hole
      assign regs_w[g] = '0;
    end else begin : g_live
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                r_q <= '0;
        else if (we_i && wsel_i == SEL_W'(g))       r_q <= wdata_i;
      end
      assign regs_w[g] = r_q;
    end
  end

  assign rd_data_o = regs_w[rd_sel_i];

  // pair p = {code 2p, code 2p+1}
  always_comb begin
    pair_data_o = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (pair_sel_i == 2'(p)) pair_data_o = {regs_w[2*p], regs_w[2*p+1]};
    end
  end
endmodule

// File: rtl/imm_load_seq.sv
module imm_load_seq
  import ils_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_rd_o,
  input  logic [DATA_W-1:0]   mem_data_i,
  output logic [1:0]          mcycle_o,
  output logic [TS_W-1:0]     tstate_o,
  output logic [ADDR_W-1:0]   pc_o,
  output logic                done_o,
  output logic                illegal_o,
  input  logic [SEL_W-1:0]    rd_sel_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [1:0]          pair_sel_i,
  output logic [2*DATA_W-1:0] pair_data_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic              legal, op_take, data_take;
  logic [SEL_W-1:0]  dst;
  mcycle_e           mc;

  ils_decode #(.DATA_W(DATA_W)) u_decode (
    .opcode_i (ir_q),
    .legal_o  (legal),
    .dst_o    (dst)
  );

  ils_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .legal_i     (legal),
    .mcycle_o    (mc),
    .tstate_o    (tstate_o),
    .rd_o        (mem_rd_o),
    .op_take_o   (op_take),
    .data_take_o (data_take),
    .done_o      (done_o),
    .illegal_o   (illegal_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (op_take)              ir_q <= mem_data_i;
      if (op_take || data_take) pc_q <= pc_q + 1'b1;
    end
  end

  ils_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (data_take),
    .wsel_i      (dst),
    .wdata_i     (mem_data_i),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o),
    .pair_sel_i  (pair_sel_i),
    .pair_data_o (pair_data_o)
  );

  assign mem_addr_o = pc_q;
  assign pc_o       = pc_q;
  assign mcycle_o   = mc;
endmodule

// File: rtl/ils_checker.sv
module ils_checker #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_rd_o,
  input logic [1:0]        mcycle_o,
  input logic [2:0]        tstate_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              done_o,
  input logic              illegal_o
);
  logic sample_t;
  assign sample_t = (mcycle_o != 2'b00) && (tstate_o == 3'd3);

  a_r2_strobe_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (mcycle_o != 2'b00 && (tstate_o == 3'd2 || tstate_o == 3'd3)));

  a_r3_fetch_to_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcycle_o == 2'b01 && tstate_o == 3'd4 && !illegal_o) |=> (mcycle_o == 2'b10 && tstate_o == 3'd1));

  a_r3_read_to_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcycle_o == 2'b10 && tstate_o == 3'd3) |=> (mcycle_o == 2'b01 && tstate_o == 3'd1));

  a_r6_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_t |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)));

  a_r6_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_t |=> $stable(pc_o));

  a_r7_done_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mcycle_o == 2'b10 && tstate_o == 3'd3));

  a_r7_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, illegal_o}));

  a_r8_illegal_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (mcycle_o == 2'b01 && tstate_o == 3'd4));

  a_r8_illegal_refetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> (mcycle_o == 2'b01 && tstate_o == 3'd1));

  a_r11_idle_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcycle_o == 2'b00) |=> (mcycle_o == 2'b01 && tstate_o == 3'd1));
endmodule

bind imm_load_seq ils_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mem_rd_o  (mem_rd_o),
  .mcycle_o  (mcycle_o),
  .tstate_o  (tstate_o),
  .pc_o      (pc_o),
  .done_o    (done_o),
  .illegal_o (illegal_o)
);

// File: tb/imm_load_seq_tb.sv
`timescale 1ns/1ps
module imm_load_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_data;
  logic [1:0]  mcycle;
  logic [2:0]  tstate;
  logic [15:0] pc;
  logic        done, illegal;
  logic [2:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic [1:0]  pair_sel = '0;
  logic [15:0] pair_data;

  always #2.5 clk = ~clk;

  logic [7:0] mem [256];
  assign mem_data = mem[mem_addr[7:0]];

  imm_load_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_data_i(mem_data), .mcycle_o(mcycle), .tstate_o(tstate), .pc_o(pc),
    .done_o(done), .illegal_o(illegal), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .pair_sel_i(pair_sel), .pair_data_o(pair_data)
  );

  int errors = 0, checks = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural reference model
  int unsigned m_mc, m_t, m_pc;
  logic [7:0]  m_ir;
  logic [7:0]  m_reg [8];

  function automatic bit is_legal(input logic [7:0] op);
    return op[7:6] == 2'b00 && op[2:0] == 3'b110 && op[5:3] != 3'b110;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mc = 0; m_t = 0; m_pc = 0; m_ir = 8'h00;
      for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    end else if (m_mc == 0) begin
      m_mc = 1; m_t = 1;
    end else if (m_mc == 1) begin
      if (m_t == 3) begin
        m_ir = mem[m_pc[7:0]]; m_pc = (m_pc + 1) & 16'hFFFF; m_t = 4;
      end else if (m_t == 4) begin
        m_mc = is_legal(m_ir) ? 2 : 1; m_t = 1;
      end else m_t++;
    end else begin
      if (m_t == 3) begin
        m_reg[m_ir[5:3]] = mem[m_pc[7:0]]; m_pc = (m_pc + 1) & 16'hFFFF;
        m_mc = 1; m_t = 1;
      end else m_t++;
    end
  end

  function automatic logic [15:0] exp_pair(input logic [1:0] s);
    case (s)
      2'd0: return {m_reg[0], m_reg[1]};
      2'd1: return {m_reg[2], m_reg[3]};
      2'd2: return {m_reg[4], m_reg[5]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic compare_cycle();
    bit e_rd, e_done, e_ill;
    string rq;
    e_rd   = (m_mc != 0) && (m_t == 2 || m_t == 3);
    e_done = (m_mc == 2) && (m_t == 3);
    e_ill  = (m_mc == 1) && (m_t == 4) && !is_legal(m_ir);
    rq = (m_mc == 2) ? "R3" : "R2";
    chk(mcycle == 2'(m_mc), rq, "mcycle", 16'(mcycle), 16'(m_mc));
    chk(tstate == 3'(m_t), rq, "tstate", 16'(tstate), 16'(m_t));
    chk(mem_rd == e_rd, "R2", "mem_rd", 16'(mem_rd), 16'(e_rd));
    chk(pc == 16'(m_pc), "R6", "pc", pc, 16'(m_pc));
    chk(done == e_done, "R7", "done", 16'(done), 16'(e_done));
    chk(illegal == e_ill, "R8", "illegal", 16'(illegal), 16'(e_ill));
    chk(rd_data == ((rd_sel == 3'b110) ? 8'h00 : m_reg[rd_sel]), "R9", "rd_data",
        16'(rd_data), 16'((rd_sel == 3'b110) ? 8'h00 : m_reg[rd_sel]));
    chk(pair_data == exp_pair(pair_sel), "R10", "pair_data", pair_data, exp_pair(pair_sel));
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int done_cnt, ill_cnt, last_done, after;
    logic [7:0] prog [22];
    prog = '{8'h3E, 8'h11, 8'h06, 8'h22, 8'h0E, 8'h33, 8'h16, 8'h44,
             8'h1E, 8'hAB, 8'h26, 8'h55, 8'h2E, 8'h66, 8'h36, 8'hFF,
             8'h00, 8'h1E, 8'h77, 8'h06, 8'h00, 8'h00};
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 22; i++) mem[i] = prog[i];

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 / R11: reset state
    chk(pc == 16'h0, "R1", "reset pc", pc, 16'h0);
    chk(mcycle == 2'b00, "R11", "reset status", 16'(mcycle), 16'h0);
    chk(!done && !illegal, "R1", "reset pulses", 16'({done, illegal}), 16'h0);
    rst_n = 1'b1;

    done_cnt = 0; ill_cnt = 0; last_done = -1; after = 0;
    for (int cyc = 0; cyc < 2000 && after < 12; cyc++) begin
      @(negedge clk);
      compare_cycle();
      if (illegal) ill_cnt++;
      if (done) begin
        done_cnt++;
        // R3: back-to-back legal instructions take 7 cycles each
        if (done_cnt >= 2 && done_cnt <= 7)
          chk(cyc - last_done == 7, "R3", "done spacing", 16'(cyc - last_done), 16'd7);
        if (done_cnt == 9) begin
          chk(ill_cnt == 3, "R8", "illegal count", 16'(ill_cnt), 16'd3);
          chk(pc == 16'h0014, "R6", "pc at last done", pc, 16'h0014);
        end
        last_done = cyc;
      end
      if (done_cnt >= 9) after++;
      rd_sel   = 3'(cyc % 8);
      pair_sel = 2'(cyc % 4);
    end
    chk(done_cnt == 9, "R7", "done count", 16'(done_cnt), 16'd9);

    // directed register reads; only illegal no-ops run now
    rd_sel = 3'b111; #0.5 chk(rd_data == 8'h11, "R4", "A", 16'(rd_data), 16'h11);
    rd_sel = 3'b000; #0.5 chk(rd_data == 8'h00, "R5", "B overwritten", 16'(rd_data), 16'h00);
    rd_sel = 3'b001; #0.5 chk(rd_data == 8'h33, "R4", "C", 16'(rd_data), 16'h33);
    rd_sel = 3'b011; #0.5 chk(rd_data == 8'h77, "R5", "E overwritten", 16'(rd_data), 16'h77);
    rd_sel = 3'b101; #0.5 chk(rd_data == 8'h66, "R4", "L", 16'(rd_data), 16'h66);
    rd_sel = 3'b110; #0.5 chk(rd_data == 8'h00, "R9", "hole code", 16'(rd_data), 16'h00);
    pair_sel = 2'd0; #0.5 chk(pair_data == 16'h0033, "R10", "BC", pair_data, 16'h0033);
    pair_sel = 2'd1; #0.5 chk(pair_data == 16'h4477, "R10", "DE", pair_data, 16'h4477);
    pair_sel = 2'd2; #0.5 chk(pair_data == 16'h5566, "R10", "HL", pair_data, 16'h5566);
    pair_sel = 2'd3; #0.5 chk(pair_data == 16'h0000, "R10", "unused pair", pair_data, 16'h0);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(pc == 16'h0, "R1", "async pc", pc, 16'h0);
    chk(mcycle == 2'b00, "R1", "async status", 16'(mcycle), 16'h0);
    pair_sel = 2'd2; #0.5 chk(pair_data == 16'h0, "R1", "async HL", pair_data, 16'h0);
    rd_sel = 3'b111; #0.5 chk(rd_data == 8'h0, "R1", "async A", 16'(rd_data), 16'h0);
    summary();
  end
endmodule